// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and walks the device through its mandatory bring-up sequence. Once a start pulse arrives, it keeps the clock enable low for a long settling wait and then raises it with NOP on the bus. It then issues precharge-all, the four mode-register loads, a second precharge-all, two auto-refreshes and the closing mode-register loads. Every command lasts one clock. The gap that follows each command is a parameter counted in clock cycles.

All mode-register contents come in as parameters. The sequencer forces only the fields whose value is set by the step it is on: the DLL-reset bit of the mode register and the OCD-control field of the extended mode register. When the last load has been followed by its gap, and at least the DLL lock interval has passed since the DLL-reset load, `init_done` rises. The controller may then start normal traffic, reads included.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `cke` = 0, NOP, `ba` = 0, `addr` = 0 and `init_done` = 0. After release the block waits in that state until `start` is seen high.
- R2: In the cycle after `start` is sampled high (cycle 0), `cke` stays 0 for cycles 0 to T200US-1. It is 1 from cycle T200US onward and does not fall again until the next reset.
- R3: The first precharge-all is issued at cycle T200US+T400NS.
- R4: The command code {cs_n,ras_n,cas_n,we_n} is NOP = 0111, precharge = 0010, refresh = 0001 and load-mode = 0000. Each command lasts exactly one cycle. Every other cycle carries NOP with `ba` = 0 and `addr` = 0.
- R5: A precharge-all drives `addr` bit 10 = 1 with all other address bits and `ba` at 0. The next command follows TRPA cycles later.
- R6: After the first precharge come four load-modes, each TMRD cycles after the previous command. Their `ba` values are 2 (EMR2 code), 3 (EMR3 code), 1 (EMR code with bits 9:7 cleared) and 0 (MR code with bit 8 set, DLL reset).
- R7: TMRD after the DLL-reset load comes a precharge-all. TRPA later comes a refresh, and TRFC after that a second refresh. Both refreshes drive `ba` = 0 and `addr` = 0.
- R8: TRFC after the second refresh comes a load of `ba` = 0 with the MR code and bit 8 cleared. TMRD later comes `ba` = 1 with the EMR code and bits 9:7 = 111 (OCD default). TMRD after that comes `ba` = 1 with the EMR code and bits 9:7 = 000 (OCD exit).
- R9: `init_done` rises at the later of TMRD cycles after the OCD-exit load and TDLL cycles after the DLL-reset load. It then stays 1, with `cke` = 1 and NOP, until reset, and `start` has no effect.
- R10: A `start` pulse while the sequence is running does not restart it or shift its timing.
- R11: A reset in the middle of the sequence returns the block to the state of R1. A new `start` then runs the whole sequence again from the CKE-low wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, same as the device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when seen in the idle state |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; low two bits select the mode register on a load |
| addr | output | ADDR_W | Address bus carrying A10 or the mode-register code |
| init_done | output | 1 | Initialization complete, normal operation allowed |

## Verification
The full sequence is run three times with short timing parameters and a long DLL interval. The DLL gate, not the last load, therefore sets when `init_done` rises, and the cycle before and the cycle of that rise are both compared. The parameter codes passed in have bit 8 set and bits 9:7 partly set. This tells a design that forces those fields apart from one that only copies the parameters. One run carries an extra `start` pulse during the CKE-low wait, which separates a sequencer that ignores it from one that restarts. Another run is cut by reset just after the first refresh, which tells a clean restart from one that resumes where it stopped.

// File: rtl/ddr2_init_pkg.sv
// Package: shared state encoding, command codes and address-field positions
// for the DDR2 initialization sequencer.
// Assumes: a 4-bit state fits all sequence steps.
package ddr2_init_pkg;

    // Sequence steps in issue order; each non-idle, non-done step issues one
    // command (NOP for the two waits) and then holds for its gap.
    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_CKE,
        S_WAIT_PRE,
        S_PRE_A,
        S_LM_EMR2,
        S_LM_EMR3,
        S_LM_EMR,
        S_LM_MR_RST,
        S_PRE_B,
        S_REF_A,
        S_REF_B,
        S_LM_MR,
        S_LM_OCD_DFLT,
        S_LM_OCD_EXIT,
        S_DONE
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_LM  = 4'b0000;

    // Address bits whose value the sequence step decides
    localparam int AP_BIT     = 10;
    localparam int DLLRST_BIT = 8;
    localparam int OCD_LO     = 7;

    // Next step in the fixed order
    function automatic seq_state_t step_after(input seq_state_t s);
        case (s)
            S_WAIT_CKE:    return S_WAIT_PRE;
            S_WAIT_PRE:    return S_PRE_A;
            S_PRE_A:       return S_LM_EMR2;
            S_LM_EMR2:     return S_LM_EMR3;
            S_LM_EMR3:     return S_LM_EMR;
            S_LM_EMR:      return S_LM_MR_RST;
            S_LM_MR_RST:   return S_PRE_B;
            S_PRE_B:       return S_REF_A;
            S_REF_A:       return S_REF_B;
            S_REF_B:       return S_LM_MR;
            S_LM_MR:       return S_LM_OCD_DFLT;
            S_LM_OCD_DFLT: return S_LM_OCD_EXIT;
            default:       return S_DONE;
        endcase
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
// Gap timer: a single down-counter reloaded when a step issues its command.
// Assumes: load values are at least 1; last marks the final cycle of a gap.
module ddr2_init_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Reload on issue, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Gap ends when one cycle remains
    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/ddr2_init_dll_gate.sv
// DLL lock gate: counts cycles since the DLL-reset load and reports when at
// least TDLL cycles have elapsed.
// Assumes: TDLL >= 1; arm pulses for the one cycle of the DLL-reset command.
module ddr2_init_dll_gate #(
    parameter int TDLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic locked
);

    localparam int DW = $clog2(TDLL + 1);

    logic [DW-1:0] cnt_q;
    logic          run_q;

    // Count cycles after arm, saturating at TDLL
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (arm) begin
            cnt_q <= DW'(1);
            run_q <= 1'b1;
        end else if (run_q && cnt_q != DW'(TDLL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign locked = run_q && (cnt_q == DW'(TDLL));

endmodule

// File: rtl/ddr2_init_cmd_map.sv
// Command mapper: turns the current step into the command code, bank and
// address the device sees, forcing DLL-reset and OCD fields per step.
// Assumes: ADDR_W >= 11, BA_W >= 2; purely combinational.
module ddr2_init_cmd_map
    import ddr2_init_pkg::*;
#(
    parameter int              ADDR_W    = 14,
    parameter int              BA_W      = 3,
    parameter logic [ADDR_W-1:0] MR_CODE   = '0,
    parameter logic [ADDR_W-1:0] EMR_CODE  = '0,
    parameter logic [ADDR_W-1:0] EMR2_CODE = '0,
    parameter logic [ADDR_W-1:0] EMR3_CODE = '0
) (
    input  seq_state_t        state,
    input  logic              issue,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              cke
);

    localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
    localparam logic [ADDR_W-1:0] RST_MASK = ADDR_W'(1) << DLLRST_BIT;
    localparam logic [ADDR_W-1:0] OCD_MASK = ADDR_W'(3'b111) << OCD_LO;
    localparam logic [ADDR_W-1:0] EMR_BASE = EMR_CODE & ~OCD_MASK;
    localparam logic [ADDR_W-1:0] MR_BASE  = MR_CODE & ~RST_MASK;

    // Clock enable stays low only before and during the settling wait
    assign cke = !(state == S_IDLE || state == S_WAIT_CKE);

    // Decode step into bus values on its issue cycle, NOP elsewhere
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (issue) begin
            case (state)
                S_PRE_A, S_PRE_B: begin
                    cmd  = CMD_PRE;
                    addr = AP_MASK;
                end
                S_REF_A, S_REF_B: cmd = CMD_REF;
                S_LM_EMR2: begin
                    cmd  = CMD_LM;
                    ba   = BA_W'(2);
                    addr = EMR2_CODE;
                end
                S_LM_EMR3: begin
                    cmd  = CMD_LM;
                    ba   = BA_W'(3);
                    addr = EMR3_CODE;
                end
                S_LM_EMR, S_LM_OCD_EXIT: begin
                    cmd  = CMD_LM;
                    ba   = BA_W'(1);
                    addr = EMR_BASE;
                end
                S_LM_OCD_DFLT: begin
                    cmd  = CMD_LM;
                    ba   = BA_W'(1);
                    addr = EMR_BASE | OCD_MASK;
                end
                S_LM_MR_RST: begin
                    cmd  = CMD_LM;
                    addr = MR_BASE | RST_MASK;
                end
                S_LM_MR: begin
                    cmd  = CMD_LM;
                    addr = MR_BASE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 initialization sequencer top: steps through the fixed bring-up order,
// one command per step followed by a parameter gap, and raises init_done once
// the sequence is over and the DLL lock interval has passed.
// Assumes: all gap parameters >= 2 cycles; synchronous active-low reset.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int                T200US    = 40000,
    parameter int                T400NS    = 80,
    parameter int                TRPA      = 4,
    parameter int                TMRD      = 2,
    parameter int                TRFC      = 40,
    parameter int                TDLL      = 200,
    parameter int                ADDR_W    = 14,
    parameter int                BA_W      = 3,
    parameter logic [ADDR_W-1:0] MR_CODE   = 14'h0a53,
    parameter logic [ADDR_W-1:0] EMR_CODE  = 14'h0044,
    parameter logic [ADDR_W-1:0] EMR2_CODE = 14'h0000,
    parameter logic [ADDR_W-1:0] EMR3_CODE = 14'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int GMAX_A = (T200US > T400NS) ? T200US : T400NS;
    localparam int GMAX_B = (TRPA > TMRD) ? TRPA : TMRD;
    localparam int GMAX_C = (GMAX_A > GMAX_B) ? GMAX_A : GMAX_B;
    localparam int GMAX   = (GMAX_C > TRFC) ? GMAX_C : TRFC;
    localparam int CW     = $clog2(GMAX + 1);

    seq_state_t    state_q, state_d;
    logic          in_gap_q, in_gap_d;
    logic          issue;
    logic          tmr_last;
    logic          dll_locked;
    logic [CW-1:0] gap_m1;
    logic [3:0]    cmd;

    // Issue cycle: first cycle of any active step
    assign issue = !in_gap_q && state_q != S_IDLE && state_q != S_DONE;

    // Select the gap that follows the current step, minus the issue cycle
    always_comb begin
        case (state_q)
            S_WAIT_CKE:       gap_m1 = CW'(T200US - 1);
            S_WAIT_PRE:       gap_m1 = CW'(T400NS - 1);
            S_PRE_A, S_PRE_B: gap_m1 = CW'(TRPA - 1);
            S_REF_A, S_REF_B: gap_m1 = CW'(TRFC - 1);
            default:          gap_m1 = CW'(TMRD - 1);
        endcase
    end

    // Step sequencing: idle waits for start, steps advance when the gap ends
    always_comb begin
        state_d  = state_q;
        in_gap_d = in_gap_q;
        case (state_q)
            S_IDLE: if (start) begin
                state_d  = S_WAIT_CKE;
                in_gap_d = 1'b0;
            end
            S_DONE: ;
            default: begin
                if (!in_gap_q) begin
                    in_gap_d = 1'b1;
                end else if (tmr_last) begin
                    state_d  = step_after(state_q);
                    in_gap_d = 1'b0;
                end
            end
        endcase
    end

    // State registers with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            in_gap_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            in_gap_q <= in_gap_d;
        end
    end

    ddr2_init_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue),
        .load_val (gap_m1),
        .last     (tmr_last)
    );

    ddr2_init_dll_gate #(.TDLL(TDLL)) u_dll_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (issue && state_q == S_LM_MR_RST),
        .locked (dll_locked)
    );

    ddr2_init_cmd_map #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MR_CODE   (MR_CODE),
        .EMR_CODE  (EMR_CODE),
        .EMR2_CODE (EMR2_CODE),
        .EMR3_CODE (EMR3_CODE)
    ) u_cmd_map (
        .state (state_q),
        .issue (issue),
        .cmd   (cmd),
        .ba    (ba),
        .addr  (addr),
        .cke   (cke)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // Done once sequence finished and DLL interval elapsed
    assign init_done = (state_q == S_DONE) && dll_locked;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Checker for the DDR2 initialization sequencer, bound to every instance.
// Assumes: port-level view only; keeps its own DLL-interval counter.
module ddr2_init_seq_chk
    import ddr2_init_pkg::*;
#(
    parameter int TDLL   = 200,
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    localparam int DW = $clog2(TDLL + 1);

    logic [3:0]    cmd;
    logic [DW-1:0] since_rst_lm;
    logic          rst_lm_seen;
    logic          rst_low_q = 1'b0;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    // Track cycles since the last load-mode with DLL reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_lm <= '0;
            rst_lm_seen  <= 1'b0;
        end else if (cmd == CMD_LM && ba[1:0] == 2'b00 && addr[DLLRST_BIT]) begin
            since_rst_lm <= DW'(1);
            rst_lm_seen  <= 1'b1;
        end else if (rst_lm_seen && since_rst_lm != DW'(TDLL)) begin
            since_rst_lm <= since_rst_lm + 1'b1;
        end
    end

    // Remember whether reset was sampled at the last edge
    always @(posedge clk) rst_low_q <= !rst_n;

    // R1
    always @(negedge clk) begin
        if (rst_low_q)
            reset_state_chk: assert (!cke && cmd == CMD_NOP && !init_done);
    end

    // R4
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_PRE || cmd == CMD_REF || cmd == CMD_LM));

    // R4
    one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R5
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (addr[AP_BIT] && ba == '0));

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && cmd == CMD_NOP));

    // R9
    dll_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (rst_lm_seen && since_rst_lm == DW'(TDLL)));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .TDLL   (TDLL),
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;

    localparam int T200 = 20;
    localparam int T400 = 5;
    localparam int TRPA = 3;
    localparam int TMRD = 2;
    localparam int TRFC = 10;
    localparam int TDLL = 200;
    localparam int AW   = 14;
    localparam int BW   = 3;

    // Expected issue cycles, counted from the cycle after start is sampled
    localparam int O_PRE1 = T200 + T400;
    localparam int O_EMR2 = O_PRE1 + TRPA;
    localparam int O_EMR3 = O_EMR2 + TMRD;
    localparam int O_EMR  = O_EMR3 + TMRD;
    localparam int O_MRD  = O_EMR + TMRD;
    localparam int O_PRE2 = O_MRD + TMRD;
    localparam int O_REF1 = O_PRE2 + TRPA;
    localparam int O_REF2 = O_REF1 + TRFC;
    localparam int O_MR   = O_REF2 + TRFC;
    localparam int O_OCDD = O_MR + TMRD;
    localparam int O_OCDX = O_OCDD + TMRD;
    localparam int O_END  = O_OCDX + TMRD;
    localparam int K_DONE = (O_END > O_MRD + TDLL) ? O_END : O_MRD + TDLL;
    localparam int N_CMD  = 11;
    localparam int K_LAST = K_DONE + 6;

    // Stimulus/expect table: offset, command, bank, address
    localparam int         EXP_OFF [N_CMD] = '{O_PRE1, O_EMR2, O_EMR3, O_EMR, O_MRD,
                                               O_PRE2, O_REF1, O_REF2, O_MR, O_OCDD, O_OCDX};
    localparam logic [3:0] EXP_CMD [N_CMD] = '{4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
                                               4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000};
    localparam int         EXP_BA  [N_CMD] = '{0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1};
    localparam logic [13:0] EXP_AD [N_CMD] = '{14'h0400, 14'h0080, 14'h0011, 14'h0044, 14'h0153,
                                               14'h0400, 14'h0000, 14'h0000, 14'h0053, 14'h03c4,
                                               14'h0044};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    logic [3:0]    cmd_w;
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;
    bit            ended = 1'b0;

    assign cmd_w = {cs_n, ras_n, cas_n, we_n};

    always #10 clk = ~clk;

    ddr2_init_seq #(
        .T200US (T200), .T400NS (T400), .TRPA (TRPA), .TMRD (TMRD), .TRFC (TRFC),
        .TDLL (TDLL), .ADDR_W (AW), .BA_W (BW),
        .MR_CODE (14'h0153), .EMR_CODE (14'h01c4),
        .EMR2_CODE (14'h0080), .EMR3_CODE (14'h0011)
    ) i_ddr2_init_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Idle / reset-state outputs
    task automatic chk_idle(input string tag);
        chk(cke == 1'b0, tag, "cke", cke, 0);
        chk(cmd_w == 4'b0111, tag, "cmd", cmd_w, 4'b0111);
        chk(ba == '0 && addr == '0, tag, "ba/addr", {ba, addr}, 0);
        chk(init_done == 1'b0, tag, "init_done", init_done, 0);
    endtask

    // Compare one sequence cycle k against the table
    task automatic check_cycle(input int k);
        logic [3:0]  ecmd = 4'b0111;
        int          eba  = 0;
        logic [13:0] ead  = '0;
        string       tag  = "R4";
        for (int e = 0; e < N_CMD; e++) begin
            if (EXP_OFF[e] == k) begin
                ecmd = EXP_CMD[e];
                eba  = EXP_BA[e];
                ead  = EXP_AD[e];
                if (e == 0)                 tag = "R3";
                else if (ecmd == 4'b0010)   tag = "R5";
                else if (ecmd == 4'b0001)   tag = "R7";
                else if (e < 5)             tag = "R6";
                else                        tag = "R8";
            end
        end
        chk(cmd_w == ecmd, tag, $sformatf("cmd k=%0d", k), cmd_w, ecmd);
        chk(ba == BW'(eba), tag, $sformatf("ba k=%0d", k), ba, eba);
        chk(addr == ead, tag, $sformatf("addr k=%0d", k), addr, ead);
        chk(cke == (k >= T200), "R2", $sformatf("cke k=%0d", k), cke, k >= T200);
        chk(init_done == (k >= K_DONE), "R9", $sformatf("init_done k=%0d", k),
            init_done, k >= K_DONE);
    endtask

    // Pulse start, then check cycles 0..last_k; optional extra start at repulse_k
    task automatic run_seq(input int last_k, input int repulse_k);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k <= last_k; k++) begin
            if (k > 0) @(negedge clk);
            start = 1'b0;
            check_cycle(k);
            if (k == T200 && repulse_k >= 0)
                chk(cke == 1'b1, "R10", "cke rise after extra start", cke, 1);
            if (k == O_PRE1 && repulse_k >= 0)
                chk(cmd_w == 4'b0010, "R10", "first PRE unshifted", cmd_w, 4'b0010);
            if (k == repulse_k) start = 1'b1;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state, then idle without start
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_idle("R1");
        end

        // Main run with an extra start during the CKE-low wait (R10)
        run_seq(K_LAST, 10);

        // R9: start after done has no effect, done holds
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk(init_done == 1'b1, "R9", "done holds", init_done, 1);
            chk(cke == 1'b1 && cmd_w == 4'b0111, "R9", "quiet after done",
                {cke, cmd_w}, 5'b10111);
            @(negedge clk);
        end

        // R11: reset after done, then partial run cut by reset
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R11");
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk_idle("R1");
        end
        run_seq(O_REF1 + 1, -1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R11");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R11");

        // R11: full rerun after mid-sequence reset
        run_seq(K_LAST, -1);
        finish_run();
    end

endmodule